// File: doc/BRIEF.md
# GPIO Edge Interrupt Controller

This block watches a set of general-purpose input lines, organised as banks of 32 lines, and turns selected transitions into interrupts for a parent interrupt controller. Each line is first passed through a multi-flop synchroniser. It is then compared with its previous synchronised sample. A per-line polarity bit picks whether a rising or a falling transition counts as an event. Only edges are detected; there is no level mode.

Every qualifying event sets a sticky pending bit, whether or not the line is enabled. Software clears a pending bit by writing a one to it. The combined interrupt output reports any pending line whose enable bit is set. A separate wakeup request output reports any pending line whose wakeup bit is set, independently of the enable bits.

Software reaches the enable, polarity, pending and wakeup registers through a single-cycle register port. Writes are strobed. Reads are combinational from the address.

Top module: `gpio_edge_irq`

## Requirements
- R1: After reset the enable, polarity, pending and wakeup registers of every bank read zero, and both `irq_o` and `wake_o` are low.
- R2: With polarity 0 a low-to-high transition on a line sets its pending bit, and a high-to-low transition does not. The pending bit is visible on the third rising clock edge after the input changes.
- R3: With polarity 1 a high-to-low transition on a line sets its pending bit, and a low-to-high transition does not.
- R4: A pending bit is latched even when the line's enable bit is 0, and such a line does not assert `irq_o`.
- R5: `irq_o` is high exactly when some line in any bank has both its pending bit and its enable bit set.
- R6: `wake_o` is high exactly when some line has both its pending bit and its wakeup bit set, whatever the enable bits hold.
- R7: Writing a 1 to a pending bit clears it on the next clock edge. Writing a 0 leaves that bit unchanged.
- R8: If a qualifying edge reaches a line's pending bit in the same cycle as a write-1-to-clear of that bit, the bit remains set.
- R9: Byte offsets select the registers as follows: enable is 0x00 + 4*bank, polarity is 0x08 + 4*bank, pending is 0x10 + 4*bank and wakeup is 0x18 + 4*bank. Bank 0 holds lines 0..31 and bank 1 holds lines 32..63, with line n at bit n mod 32. Enable, polarity and wakeup read back what was last written.
- R10: A read from any offset outside that map returns zero, and a write to any such offset changes no register.
- R11: Changing a polarity bit while its line is steady does not set the pending bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| gpio_in | input | NUM_BANKS*BANK_W | Asynchronous input lines |
| reg_we | input | 1 | Register write strobe, one cycle per write |
| reg_addr | input | ADDR_W | Register byte offset |
| reg_wdata | input | DATA_W | Write data |
| reg_rdata | output | DATA_W | Read data for `reg_addr`, combinational |
| irq_o | output | 1 | Combined interrupt to the parent controller |
| wake_o | output | 1 | Wakeup request |

## Verification
The previous-sample register or a pending bit could take a wrong value, for example from a missed edge, the wrong polarity, or a clear that beats a same-cycle edge. Any of these shows at the pending register read-back on the third clock edge after the input change, and at `irq_o` or `wake_o` in the same cycle when the line is enabled or wake-armed. The bench walks every one of the 64 lines through both polarities and through the acknowledge path. It also reads every offset of the address space, so a stuck, swapped or aliased bit appears within a few cycles of the stimulus that should have touched it.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;
   // register kind lives in byte-offset bits [4:3]; bank in bit [2]
   typedef enum logic [1:0] {
      KIND_ENABLE  = 2'd0,
      KIND_POLAR   = 2'd1,
      KIND_PENDING = 2'd2,
      KIND_WAKE    = 2'd3
   } reg_kind_e;

   localparam int unsigned KIND_LSB = 3;
   localparam int unsigned BANK_LSB = 2;
   localparam int unsigned MAP_BITS = 5;
endpackage

// File: rtl/gpio_irq_sync.sv
module gpio_irq_sync #(
   parameter int unsigned WIDTH  = 64,
   parameter int unsigned STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] din,
   output logic [WIDTH-1:0] dout
);
   logic [WIDTH-1:0] chain_q [STAGES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int s = 0; s < int'(STAGES); s++) chain_q[s] <= '0;
      end else begin
         chain_q[0] <= din;
         for (int s = 1; s < int'(STAGES); s++) chain_q[s] <= chain_q[s-1];
      end
   end

   assign dout = chain_q[STAGES-1];
endmodule

// File: rtl/gpio_irq_edge.sv
module gpio_irq_edge #(
   parameter int unsigned WIDTH = 64
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] level_i,
   input  logic [WIDTH-1:0] pol_i,
   output logic [WIDTH-1:0] event_o
);
   logic [WIDTH-1:0] prev_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q <= '0;
      else        prev_q <= level_i;
   end

   // a transition whose new level differs from the polarity bit:
   // pol 0 -> new level 1 (rising), pol 1 -> new level 0 (falling)
   assign event_o = (level_i ^ prev_q) & (level_i ^ pol_i);
endmodule

// File: rtl/gpio_irq_regs.sv
module gpio_irq_regs
   import gpio_irq_pkg::*;
#(
   parameter int unsigned NUM_BANKS = 2,
   parameter int unsigned BANK_W    = 32,
   parameter int unsigned ADDR_W    = 8,
   parameter int unsigned DATA_W    = 32,
   localparam int unsigned NUM_LINES = NUM_BANKS * BANK_W
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 we_i,
   input  logic [ADDR_W-1:0]    addr_i,
   input  logic [DATA_W-1:0]    wdata_i,
   input  logic [NUM_LINES-1:0] event_i,
   output logic [DATA_W-1:0]    rdata_o,
   output logic [NUM_LINES-1:0] en_o,
   output logic [NUM_LINES-1:0] pol_o,
   output logic [NUM_LINES-1:0] pend_o,
   output logic [NUM_LINES-1:0] wake_o
);
   reg_kind_e kind;
   logic      bank_bit;
   logic      hit;

   always_comb begin
      kind     = reg_kind_e'(addr_i[KIND_LSB +: 2]);
      bank_bit = addr_i[BANK_LSB];
      hit      = (addr_i[1:0] == 2'b00)
              && ((addr_i >> MAP_BITS) == '0)
              && (int'(bank_bit) < int'(NUM_BANKS));
   end

   logic [DATA_W-1:0] bank_rd [NUM_BANKS];

   for (genvar b = 0; b < int'(NUM_BANKS); b++) begin : g_bank
      localparam logic BSEL = 1'(b);
      logic              sel;
      logic [BANK_W-1:0] clr;
      logic [BANK_W-1:0] en_q, pol_q, pend_q, wk_q;

      assign sel = hit && (bank_bit == BSEL);
      assign clr = (we_i && sel && kind == KIND_PENDING) ? wdata_i[BANK_W-1:0] : '0;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            en_q  <= '0;
            pol_q <= '0;
            wk_q  <= '0;
         end else if (we_i && sel) begin
            case (kind)
               KIND_ENABLE: en_q  <= wdata_i[BANK_W-1:0];
               KIND_POLAR:  pol_q <= wdata_i[BANK_W-1:0];
               KIND_WAKE:   wk_q  <= wdata_i[BANK_W-1:0];
               default:     ;
            endcase
         end
      end

      // a fresh event outranks a same-cycle acknowledge
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) pend_q <= '0;
         else        pend_q <= (pend_q & ~clr) | event_i[b*BANK_W +: BANK_W];
      end

      assign en_o  [b*BANK_W +: BANK_W] = en_q;
      assign pol_o [b*BANK_W +: BANK_W] = pol_q;
      assign pend_o[b*BANK_W +: BANK_W] = pend_q;
      assign wake_o[b*BANK_W +: BANK_W] = wk_q;

      always_comb begin
         bank_rd[b] = '0;
         if (sel) begin
            case (kind)
               KIND_ENABLE:  bank_rd[b] = DATA_W'(en_q);
               KIND_POLAR:   bank_rd[b] = DATA_W'(pol_q);
               KIND_PENDING: bank_rd[b] = DATA_W'(pend_q);
               KIND_WAKE:    bank_rd[b] = DATA_W'(wk_q);
               default:      bank_rd[b] = '0;
            endcase
         end
      end
   end

   always_comb begin
      rdata_o = '0;
      for (int b = 0; b < int'(NUM_BANKS); b++) rdata_o = rdata_o | bank_rd[b];
   end
endmodule

// File: rtl/gpio_edge_irq.sv
module gpio_edge_irq #(
   parameter int unsigned NUM_BANKS   = 2,
   parameter int unsigned BANK_W      = 32,
   parameter int unsigned ADDR_W      = 8,
   parameter int unsigned DATA_W      = 32,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic [NUM_BANKS*BANK_W-1:0]   gpio_in,
   input  logic                          reg_we,
   input  logic [ADDR_W-1:0]             reg_addr,
   input  logic [DATA_W-1:0]             reg_wdata,
   output logic [DATA_W-1:0]             reg_rdata,
   output logic                          irq_o,
   output logic                          wake_o
);
   localparam int unsigned NUM_LINES = NUM_BANKS * BANK_W;

   if (NUM_BANKS < 1 || NUM_BANKS > 2) begin : g_bad_banks
      $error("NUM_BANKS must be 1 or 2");
   end
   if (BANK_W < 1 || BANK_W > DATA_W || BANK_W > 32) begin : g_bad_width
      $error("BANK_W must be 1..min(DATA_W,32)");
   end
   if (ADDR_W < 5) begin : g_bad_addr
      $error("ADDR_W must cover the 32-byte register map");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("SYNC_STAGES must be at least 2");
   end

   logic [NUM_LINES-1:0] level_s;
   logic [NUM_LINES-1:0] event_vec;
   logic [NUM_LINES-1:0] en_q, pol_q, pend_q, wk_q;

   gpio_irq_sync #(.WIDTH(NUM_LINES), .STAGES(SYNC_STAGES)) u_sync (
      .clk  (clk),
      .rst_n(rst_n),
      .din  (gpio_in),
      .dout (level_s)
   );

   gpio_irq_edge #(.WIDTH(NUM_LINES)) u_edge (
      .clk    (clk),
      .rst_n  (rst_n),
      .level_i(level_s),
      .pol_i  (pol_q),
      .event_o(event_vec)
   );

   gpio_irq_regs #(
      .NUM_BANKS(NUM_BANKS),
      .BANK_W   (BANK_W),
      .ADDR_W   (ADDR_W),
      .DATA_W   (DATA_W)
   ) u_regs (
      .clk    (clk),
      .rst_n  (rst_n),
      .we_i   (reg_we),
      .addr_i (reg_addr),
      .wdata_i(reg_wdata),
      .event_i(event_vec),
      .rdata_o(reg_rdata),
      .en_o   (en_q),
      .pol_o  (pol_q),
      .pend_o (pend_q),
      .wake_o (wk_q)
   );

   assign irq_o  = |(pend_q & en_q);
   assign wake_o = |(pend_q & wk_q);
endmodule

// File: rtl/gpio_irq_chk.sv
module gpio_irq_chk #(
   parameter int unsigned NUM_BANKS = 2,
   parameter int unsigned BANK_W    = 32,
   parameter int unsigned ADDR_W    = 8,
   parameter int unsigned DATA_W    = 32,
   localparam int unsigned NUM_LINES = NUM_BANKS * BANK_W
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic                 reg_we,
   input logic [ADDR_W-1:0]    reg_addr,
   input logic [DATA_W-1:0]    reg_wdata,
   input logic [DATA_W-1:0]    reg_rdata,
   input logic                 irq_o,
   input logic                 wake_o,
   input logic [NUM_LINES-1:0] en_q,
   input logic [NUM_LINES-1:0] wk_q,
   input logic [NUM_LINES-1:0] pend_q,
   input logic [NUM_LINES-1:0] event_vec
);
   logic                 mapped;
   logic [NUM_LINES-1:0] ack_vec;

   always_comb begin
      mapped  = (reg_addr[1:0] == 2'b00) && (int'(reg_addr) < 32)
             && (int'(reg_addr[2]) < int'(NUM_BANKS));
      ack_vec = '0;
      if (reg_we && mapped && reg_addr[4:3] == 2'd2)
         ack_vec[int'(reg_addr[2])*BANK_W +: BANK_W] = reg_wdata[BANK_W-1:0];
   end

   AST_RESET_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> (pend_q == '0 && en_q == '0 && wk_q == '0)); // R1
   AST_PEND_FROM_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
      ((pend_q & ~$past(pend_q) & ~$past(event_vec)) == '0)); // R2
   AST_EVENT_BEATS_ACK: assert property (@(posedge clk) disable iff (!rst_n)
      ((pend_q & $past(event_vec)) == $past(event_vec))); // R8
   AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      ((pend_q & $past(ack_vec) & ~$past(event_vec)) == '0)); // R7
   AST_IRQ_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
      irq_o |-> |(pend_q & en_q)); // R4
   AST_IRQ_RAISED: assert property (@(posedge clk) disable iff (!rst_n)
      |(pend_q & en_q) |-> irq_o); // R5
   AST_WAKE_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
      wake_o == |(pend_q & wk_q)); // R6
   AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      !mapped |-> reg_rdata == '0); // R10
endmodule

bind gpio_edge_irq gpio_irq_chk #(
   .NUM_BANKS(NUM_BANKS),
   .BANK_W   (BANK_W),
   .ADDR_W   (ADDR_W),
   .DATA_W   (DATA_W)
) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .reg_we   (reg_we),
   .reg_addr (reg_addr),
   .reg_wdata(reg_wdata),
   .reg_rdata(reg_rdata),
   .irq_o    (irq_o),
   .wake_o   (wake_o),
   .en_q     (en_q),
   .wk_q     (wk_q),
   .pend_q   (pend_q),
   .event_vec(event_vec)
);

// File: tb/sim_gpio_edge_irq.sv
module sim_gpio_edge_irq;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [63:0] gpio_in = '0;
   logic        reg_we = 1'b0;
   logic [7:0]  reg_addr = '0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic        irq_o, wake_o;

   int checks = 0;
   int errors = 0;
   bit finished = 1'b0;

   always #10 clk = ~clk; // 50 MHz

   gpio_edge_irq u0 (
      .clk(clk), .rst_n(rst_n), .gpio_in(gpio_in),
      .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
      .reg_rdata(reg_rdata), .irq_o(irq_o), .wake_o(wake_o)
   );

   localparam logic [7:0] A_EN = 8'h00, A_POL = 8'h08, A_PEND = 8'h10, A_WAKE = 8'h18;

   task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
      checks++;
      if (got !== exp) begin
         errors++;
         $display("FAIL %s got=%h exp=%h", tag, got, exp);
      end
   endtask

   task automatic wr(input logic [7:0] a, input logic [31:0] d);
      @(negedge clk);
      reg_we = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk);
      reg_we = 1'b0;
   endtask

   task automatic rd(input logic [7:0] a, output logic [31:0] d);
      @(negedge clk);
      reg_addr = a;
      #2 d = reg_rdata;
   endtask

   task automatic settle();
      repeat (3) @(posedge clk);
      @(negedge clk);
   endtask

   task automatic drive(input int line, input logic v);
      @(negedge clk);
      gpio_in[line] = v;
      settle();
   endtask

   task automatic summary();
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         checks++; errors++;
         $display("FAIL watchdog expired");
         summary();
      end
   end

   initial begin
      logic [31:0] d;
      repeat (3) @(posedge clk);
      @(negedge clk) rst_n = 1'b1;
      @(negedge clk);

      // R1: reset state
      for (int k = 0; k < 8; k++) begin
         rd(8'(k * 4), d);
         chk($sformatf("R1 reg@%0h", k * 4), d, 32'h0);
      end
      chk("R1 irq", {31'h0, irq_o}, 32'h0);
      chk("R1 wake", {31'h0, wake_o}, 32'h0);

      // R9: map and read-back of enable/polarity/wakeup in both banks
      for (int k = 0; k < 8; k++) begin
         if (k / 2 != 2) wr(8'(k * 4), 32'h5A3C0F00 ^ (32'(k) * 32'h01010101));
      end
      for (int k = 0; k < 8; k++) begin
         rd(8'(k * 4), d);
         chk($sformatf("R9 readback @%0h", k * 4), d,
             (k / 2 == 2) ? 32'h0 : (32'h5A3C0F00 ^ (32'(k) * 32'h01010101)));
      end
      chk("R11 polarity write sets nothing", {31'h0, irq_o | wake_o}, 32'h0);

      // R10: every unmapped offset reads zero; writes there change nothing
      for (int a = 0; a < 256; a++) begin
         if (!((a % 4) == 0 && a < 32)) begin
            rd(8'(a), d);
            chk($sformatf("R10 read @%0h", a), d, 32'h0);
         end
      end
      for (int a = 1; a < 256; a += 7) begin
         if (!((a % 4) == 0 && a < 32)) wr(8'(a), 32'hFFFFFFFF);
      end
      for (int k = 0; k < 8; k++) begin
         rd(8'(k * 4), d);
         chk($sformatf("R10 no alias @%0h", k * 4), d,
             (k / 2 == 2) ? 32'h0 : (32'h5A3C0F00 ^ (32'(k) * 32'h01010101)));
      end

      // sweep setup: all enabled, rising, no wake
      wr(A_EN, '1); wr(A_EN + 4, '1);
      wr(A_POL, '0); wr(A_POL + 4, '0);
      wr(A_WAKE, '0); wr(A_WAKE + 4, '0);

      // R2 + R7: rising edge on every line
      for (int i = 0; i < 64; i++) begin
         logic [7:0] pa; logic [7:0] oa; logic [31:0] bitv;
         pa = A_PEND + 8'((i / 32) * 4);
         oa = A_PEND + 8'((1 - i / 32) * 4);
         bitv = 32'h1 << (i % 32);
         drive(i, 1'b1);
         chk($sformatf("R2 irq line %0d", i), {31'h0, irq_o}, 32'h1);
         rd(pa, d); chk($sformatf("R2 pend line %0d", i), d, bitv);
         rd(oa, d); chk($sformatf("R2 other bank line %0d", i), d, 32'h0);
         drive(i, 1'b0);
         rd(pa, d); chk($sformatf("R2 fall ignored line %0d", i), d, bitv);
         wr(pa, ~bitv);
         rd(pa, d); chk($sformatf("R7 zero-write keeps line %0d", i), d, bitv);
         wr(pa, bitv);
         rd(pa, d); chk($sformatf("R7 ack line %0d", i), d, 32'h0);
         chk($sformatf("R7 irq drop line %0d", i), {31'h0, irq_o}, 32'h0);
      end

      // R11: flip polarity with lines steady
      wr(A_POL, '1); wr(A_POL + 4, '1);
      settle();
      rd(A_PEND, d); chk("R11 pend bank0", d, 32'h0);
      rd(A_PEND + 4, d); chk("R11 pend bank1", d, 32'h0);

      // R3: falling edge on every line
      for (int i = 0; i < 64; i++) begin
         logic [7:0] pa; logic [31:0] bitv;
         pa = A_PEND + 8'((i / 32) * 4);
         bitv = 32'h1 << (i % 32);
         drive(i, 1'b1);
         rd(pa, d); chk($sformatf("R3 rise ignored line %0d", i), d, 32'h0);
         drive(i, 1'b0);
         rd(pa, d); chk($sformatf("R3 fall line %0d", i), d, bitv);
         chk($sformatf("R3 irq line %0d", i), {31'h0, irq_o}, 32'h1);
         wr(pa, bitv);
      end
      wr(A_POL, '0); wr(A_POL + 4, '0);

      // R4 / R5: latched while disabled, enable reveals, OR across banks
      wr(A_EN, '0); wr(A_EN + 4, '0);
      drive(5, 1'b1);
      rd(A_PEND, d); chk("R4 latched while disabled", d, 32'h20);
      chk("R4 irq stays low", {31'h0, irq_o}, 32'h0);
      wr(A_EN, 32'h20);
      chk("R5 irq after enable", {31'h0, irq_o}, 32'h1);
      wr(A_EN + 4, 32'h100);
      drive(40, 1'b1);
      wr(A_PEND, 32'h20);
      chk("R5 bank1 keeps irq", {31'h0, irq_o}, 32'h1);
      wr(A_EN + 4, 32'h0);
      chk("R5 irq low when bank1 disabled", {31'h0, irq_o}, 32'h0);
      wr(A_PEND + 4, 32'h100);
      gpio_in[5] = 1'b0; gpio_in[40] = 1'b0;
      settle();

      // R6: wake independent of enable
      wr(A_WAKE + 4, 32'h100);
      drive(40, 1'b1);
      chk("R6 wake set", {31'h0, wake_o}, 32'h1);
      chk("R6 irq stays low", {31'h0, irq_o}, 32'h0);
      wr(A_PEND + 4, 32'h100);
      drive(3, 1'b1);
      chk("R6 wake low for non-wake line", {31'h0, wake_o}, 32'h0);
      wr(A_PEND, 32'h8);
      wr(A_WAKE + 4, 32'h0);
      gpio_in[3] = 1'b0; gpio_in[40] = 1'b0;
      settle();

      // R8: event and acknowledge land on the same edge
      wr(A_EN, 32'h1);
      drive(0, 1'b1);
      drive(0, 1'b0);
      @(negedge clk) gpio_in[0] = 1'b1;
      @(posedge clk); @(posedge clk);
      @(negedge clk) begin reg_we = 1'b1; reg_addr = A_PEND; reg_wdata = 32'h1; end
      @(negedge clk) reg_we = 1'b0;
      rd(A_PEND, d); chk("R8 event wins over ack", d, 32'h1);
      chk("R8 irq held", {31'h0, irq_o}, 32'h1);
      wr(A_PEND, 32'h1);
      rd(A_PEND, d); chk("R8 plain ack clears", d, 32'h0);

      finished = 1'b1;
      summary();
   end
endmodule